// File: doc/BRIEF.md
# Reference-Aligned Periodic Clock Generator

This block produces a slow periodic square wave (200 Hz with the default parameters) from a loop tick that is divided down from the system clock, and keeps the wave's phase locked to an external once-per-second reference pulse. A modulo period counter runs without interruption. The output goes high when the count reaches a compare point and goes low when the counter wraps.

The reference never resets the counter. When a rising edge of the reference is detected, the block moves the compare point to a position a fixed number of ticks after the live count. The next high phase therefore starts just after the reference and ends at the following wrap. The duty cycle of the period in which this happens is allowed to differ from half. A separate marker output is raised for a programmable number of ticks after each reference edge. Two single-cycle strobes report compare matches and detected reference edges.

The enable input gates the whole block. While it is low, every counter is held at its reset value and all outputs stay low.

Top module: `pps_phase_clkgen`

## Requirements
- R1: While enabled, a loop tick occurs once every PRESCALE system clock cycles. The period counter, the compare point, the marker timer and every output change only in the cycle after a tick, or in the cycle after the enable input goes low.
- R2: The period counter steps through 0 to CNT_MAX inclusive, one step per tick, and then returns to 0. Without realignment, compare matches are therefore (CNT_MAX+1)*PRESCALE cycles apart.
- R3: `clk_out` is low after reset and goes high on the tick where the count equals the compare point, which starts at CMP_INIT. It goes low on the tick where the count equals CNT_MAX. A match wins over a wrap on the same tick.
- R4: `ref_in` passes through two synchronizing flops. A rising edge is detected on a tick when the synchronized level is high and was low at the previous tick, or, just after enable, low when the block was enabled. A reference high level must last at least one tick to be seen.
- R5: On a detected edge at count C, the compare point becomes (C+1+ALIGN_OFS) mod (CNT_MAX+1) and the count is left untouched. The next compare match then comes exactly ALIGN_OFS+1 ticks after the detecting tick, and `clk_out` is high from that match until the next wrap.
- R6: If the value computed in R5 equals CNT_MAX, the compare point is loaded with 0 instead. The match then comes ALIGN_OFS+2 ticks after the detecting tick, and the compare point never holds CNT_MAX.
- R7: `marker` rises together with each `align_stb` and stays high for exactly MARK_TICKS ticks after the most recent detected edge. A new edge restarts the full length.
- R8: `match_stb` is a one-cycle pulse for each compare-match tick. `align_stb` is a one-cycle pulse for each detected reference edge. Both are aligned with the output update of that tick.
- R9: With `en` low, the counters and the compare point return to their reset values and all four outputs are low from the next cycle. A reference that is already high when `en` rises does not produce an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Block enable; low holds everything idle |
| ref_in | input | 1 | Asynchronous once-per-second reference |
| clk_out | output | 1 | Generated periodic clock |
| marker | output | 1 | High for MARK_TICKS ticks after each reference edge |
| match_stb | output | 1 | One-cycle pulse on each compare match |
| align_stb | output | 1 | One-cycle pulse on each detected reference edge |

## Verification
The hardest situations to reach are a reference edge that lands on the tick where the counter sits at its maximum, and one that lands where the realigned compare point would fall on the maximum. Only an edge whose timing has exactly the right phase relative to both the prescaler and the period counter reaches either case. The stimulus sends a long train of reference pulses whose spacing is stepped by an amount coprime to the period in system cycles, so every count and prescaler phase is hit. A tick-level arithmetic model predicts every output in every cycle. A short burst of closely spaced pulses exercises marker retriggering. A disable window with the reference held high checks that no edge is seen when the block is enabled again.

// File: rtl/pps_clkgen_pkg.sv
package pps_clkgen_pkg;
  // Width needed to hold values 0..max_val, never less than one bit.
  function automatic int bits_for(input int max_val);
    if (max_val < 1) return 1;
    return $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/pps_tick_gen.sv
module pps_tick_gen #(
  parameter int PRESCALE = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  import pps_clkgen_pkg::*;
  localparam int DIV_W = bits_for(PRESCALE - 1);

  generate
    if (PRESCALE == 1) begin : g_direct
      always_ff @(posedge clk) begin
        if (rst || !en) tick <= 1'b0;
        else            tick <= 1'b1;
      end
    end else begin : g_divide
      logic [DIV_W-1:0] div_q;
      always_ff @(posedge clk) begin
        if (rst || !en) begin
          div_q <= '0;
          tick  <= 1'b0;
        end else if (div_q == DIV_W'(PRESCALE - 1)) begin
          div_q <= '0;
          tick  <= 1'b1;
        end else begin
          div_q <= div_q + 1'b1;
          tick  <= 1'b0;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/pps_ref_edge.sv
module pps_ref_edge (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic tick,
  input  logic ref_in,
  output logic edge_hit
);
  logic sync1_q, sync2_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
    end else begin
      sync1_q <= ref_in;
      sync2_q <= sync1_q;
    end
  end

  // While idle the previous sample tracks the level, so enabling with the
  // reference already high does not report an edge.
  always_ff @(posedge clk) begin
    if (rst)              prev_q <= 1'b0;
    else if (!en || tick) prev_q <= sync2_q;
  end

  assign edge_hit = en & tick & sync2_q & ~prev_q;
endmodule

// File: rtl/pps_phase_core.sv
module pps_phase_core #(
  parameter int CNT_MAX   = 3124,
  parameter int CMP_INIT  = 1563,
  parameter int ALIGN_OFS = 1,
  parameter int CW        = pps_clkgen_pkg::bits_for(CNT_MAX)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          tick,
  input  logic          edge_hit,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cmp_q,
  output logic          clk_out,
  output logic          match_stb,
  output logic          align_stb
);
  localparam int PERIOD = CNT_MAX + 1;

  logic          at_max, at_cmp;
  logic [CW:0]   sum_raw, sum_mod;
  logic [CW-1:0] new_cmp;

  assign at_max = (cnt_q == CW'(CNT_MAX));
  assign at_cmp = (cnt_q == cmp_q);

  // New compare point: live count plus one step plus the offset, modulo
  // the period; the maximum itself is avoided by moving to zero.
  always_comb begin
    sum_raw = {1'b0, cnt_q} + (CW+1)'(ALIGN_OFS + 1);
    if (sum_raw > (CW+1)'(CNT_MAX)) sum_mod = sum_raw - (CW+1)'(PERIOD);
    else                            sum_mod = sum_raw;
    if (sum_mod[CW-1:0] == CW'(CNT_MAX)) new_cmp = '0;
    else                                 new_cmp = sum_mod[CW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q     <= '0;
      cmp_q     <= CW'(CMP_INIT);
      clk_out   <= 1'b0;
      match_stb <= 1'b0;
      align_stb <= 1'b0;
    end else begin
      match_stb <= 1'b0;
      align_stb <= 1'b0;
      if (tick) begin
        cnt_q     <= at_max ? '0 : cnt_q + 1'b1;
        match_stb <= at_cmp;
        align_stb <= edge_hit;
        if (at_cmp)      clk_out <= 1'b1;
        else if (at_max) clk_out <= 1'b0;
        if (edge_hit)    cmp_q   <= new_cmp;
      end
    end
  end
endmodule

// File: rtl/pps_marker_timer.sv
module pps_marker_timer #(
  parameter int MARK_TICKS = 625
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic tick,
  input  logic edge_hit,
  output logic marker
);
  import pps_clkgen_pkg::*;
  localparam int MW = bits_for(MARK_TICKS);

  logic [MW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      left_q <= '0;
      marker <= 1'b0;
    end else if (tick) begin
      if (edge_hit) begin
        left_q <= MW'(MARK_TICKS);
        marker <= 1'b1;
      end else if (left_q != '0) begin
        left_q <= left_q - 1'b1;
        if (left_q == MW'(1)) marker <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pps_phase_clkgen.sv
module pps_phase_clkgen #(
  parameter int PRESCALE   = 16,
  parameter int CNT_MAX    = 3124,
  parameter int CMP_INIT   = 1563,
  parameter int ALIGN_OFS  = 1,
  parameter int MARK_TICKS = 625
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic ref_in,
  output logic clk_out,
  output logic marker,
  output logic match_stb,
  output logic align_stb
);
  import pps_clkgen_pkg::*;
  localparam int CW = bits_for(CNT_MAX);

  logic          tick_w;
  logic          edge_w;
  logic [CW-1:0] cnt_w;
  logic [CW-1:0] cmp_w;

  pps_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
    .clk (clk),
    .rst (rst),
    .en  (en),
    .tick(tick_w)
  );

  pps_ref_edge u_edge (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .tick    (tick_w),
    .ref_in  (ref_in),
    .edge_hit(edge_w)
  );

  pps_phase_core #(
    .CNT_MAX  (CNT_MAX),
    .CMP_INIT (CMP_INIT),
    .ALIGN_OFS(ALIGN_OFS),
    .CW       (CW)
  ) u_core (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .tick     (tick_w),
    .edge_hit (edge_w),
    .cnt_q    (cnt_w),
    .cmp_q    (cmp_w),
    .clk_out  (clk_out),
    .match_stb(match_stb),
    .align_stb(align_stb)
  );

  pps_marker_timer #(.MARK_TICKS(MARK_TICKS)) u_mark (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .tick    (tick_w),
    .edge_hit(edge_w),
    .marker  (marker)
  );
endmodule

// File: rtl/pps_phase_clkgen_chk.sv
module pps_phase_clkgen_chk #(
  parameter int CNT_MAX = 3124,
  parameter int CW      = 12
) (
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic          tick,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] cmp,
  input logic          clk_out,
  input logic          marker,
  input logic          match_stb,
  input logic          align_stb
);
  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(CNT_MAX)); // R2

  AST_CNT_HOLDS_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en) && !$past(tick)) |-> $stable(cnt)); // R1

  AST_OUT_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    !$stable(clk_out) |-> ($past(tick) || !$past(en))); // R1

  AST_FALL_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
    ($fell(clk_out) && $past(en)) |-> (cnt == '0)); // R3

  AST_CMP_NEVER_MAX: assert property (@(posedge clk) disable iff (rst)
    cmp != CW'(CNT_MAX)); // R6

  AST_MARK_RISES_WITH_ALIGN: assert property (@(posedge clk) disable iff (rst)
    $rose(marker) |-> align_stb); // R7

  AST_ALIGN_SETS_MARK: assert property (@(posedge clk) disable iff (rst)
    align_stb |-> marker); // R7

  AST_MATCH_SINGLE: assert property (@(posedge clk) disable iff (rst)
    match_stb |=> !match_stb); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!clk_out && !marker && !match_stb && !align_stb)); // R9
endmodule

bind pps_phase_clkgen pps_phase_clkgen_chk #(
  .CNT_MAX(CNT_MAX),
  .CW     (CW)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .en       (en),
  .tick     (tick_w),
  .cnt      (cnt_w),
  .cmp      (cmp_w),
  .clk_out  (clk_out),
  .marker   (marker),
  .match_stb(match_stb),
  .align_stb(align_stb)
);

// File: tb/tb_pps_phase_clkgen.sv
`timescale 1ns/1ps
module tb_pps_phase_clkgen;
  localparam int P    = 2;
  localparam int MAXC = 11;
  localparam int CMPI = 6;
  localparam int OFS  = 1;
  localparam int MARK = 5;
  localparam int N    = MAXC + 1;

  logic clk = 1'b0, rst = 1'b1, en = 1'b0, ref_in = 1'b0;
  logic clk_out, marker, match_stb, align_stb;

  always #2.5 clk = ~clk;

  pps_phase_clkgen #(
    .PRESCALE(P), .CNT_MAX(MAXC), .CMP_INIT(CMPI),
    .ALIGN_OFS(OFS), .MARK_TICKS(MARK)
  ) dut (
    .clk(clk), .rst(rst), .en(en), .ref_in(ref_in),
    .clk_out(clk_out), .marker(marker),
    .match_stb(match_stb), .align_stb(align_stb)
  );

  int  n_chk = 0, n_fail = 0, cyc = 0;
  bit  done = 1'b0;

  task automatic chk(input bit ok, input string tag, input int got, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s got %0d exp %0d at cycle %0d", tag, got, exp, cyc);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Tick-level arithmetic model built from the requirements.
  int m_div = 0, m_cnt = 0, m_cmp = CMPI, m_mc = 0, m_delay = 0;
  bit m_tick = 0, m_s1 = 0, m_s2 = 0, m_prev = 0;
  bit m_out = 0, m_mark = 0, m_cs = 0, m_rs = 0;

  always @(posedge clk) begin
    bit e;
    int t;
    m_s1 <= ref_in;
    m_s2 <= m_s1;
    if (rst || !en) begin
      m_prev <= rst ? 1'b0 : m_s2;
      m_div <= 0; m_tick <= 0; m_cnt <= 0; m_cmp <= CMPI;
      m_out <= 0; m_mark <= 0; m_mc <= 0; m_cs <= 0; m_rs <= 0;
    end else begin
      m_tick <= (m_div == P - 1);
      m_div  <= (m_div + 1) % P;
      m_cs <= 0;
      m_rs <= 0;
      if (m_tick) begin
        e = m_s2 && !m_prev;
        m_prev <= m_s2;
        m_cs <= (m_cnt == m_cmp);
        m_rs <= e;
        if (m_cnt == m_cmp)    m_out <= 1;
        else if (m_cnt == MAXC) m_out <= 0;
        m_cnt <= (m_cnt == MAXC) ? 0 : m_cnt + 1;
        if (e) begin
          t = (m_cnt + 1 + OFS) % N;
          if (t == MAXC) begin t = 0; m_delay <= (OFS + 2) * P; end
          else m_delay <= (OFS + 1) * P;
          m_cmp <= t;
          m_mc <= MARK;
          m_mark <= 1;
        end else if (m_mc != 0) begin
          m_mc <= m_mc - 1;
          if (m_mc == 1) m_mark <= 0;
        end
      end
    end
  end

  // Per-cycle comparison and interval measurements, away from the edge.
  bit pend = 0, prev_mark = 0, have_m = 0, al_since = 0;
  int t0 = 0, expd = 0, last_al = 0, last_m = 0;

  always @(negedge clk) begin
    cyc++;
    if (!rst && !done) begin
      chk(clk_out == m_out,     "R3 clk_out",   clk_out,   m_out);
      chk(marker == m_mark,     "R7 marker",    marker,    m_mark);
      chk(match_stb == m_cs,    "R8 match_stb", match_stb, m_cs);
      chk(align_stb == m_rs,    "R4 align_stb", align_stb, m_rs);
      if (!en) begin
        pend = 0; have_m = 0;
      end else begin
        if (align_stb) begin
          pend = 1; t0 = cyc; expd = m_delay; last_al = cyc;
        end else if (match_stb && pend) begin
          chk(cyc - t0 == expd, (expd == (OFS + 2) * P) ? "R6 delay" : "R5 delay",
              cyc - t0, expd);
          chk(clk_out == 1'b1, "R5 high after realign", clk_out, 1);
          pend = 0;
        end
        if (prev_mark && !marker)
          chk(cyc - last_al == MARK * P, "R7 marker length", cyc - last_al, MARK * P);
        if (match_stb) begin
          if (have_m && !al_since)
            chk(cyc - last_m == N * P, "R2 match spacing", cyc - last_m, N * P);
          have_m = 1; last_m = cyc; al_since = 0;
        end
        if (align_stb) al_since = 1;
      end
      prev_mark = marker;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      finish_run();
    end
  end

  task automatic pulse(input int hi, input int lo);
    @(negedge clk) ref_in = 1'b1;
    repeat (hi) @(negedge clk);
    ref_in = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  initial begin
    int aligns;
    repeat (4) @(negedge clk);
    // Reset state R3 R9
    chk(clk_out == 0 && marker == 0, "R3 reset outputs", {clk_out, marker}, 0);
    chk(match_stb == 0 && align_stb == 0, "R9 reset strobes", {match_stb, align_stb}, 0);
    rst = 1'b0;
    en  = 1'b1;
    repeat (4 * N * P) @(negedge clk);   // free run, R1 R2 R3
    for (int i = 0; i < 48; i++) pulse(4, 30 + (i * 7) % (N * P)); // R5 R6 sweep
    for (int i = 0; i < 6; i++) pulse(3, 5 + i);  // marker retrigger R7
    repeat (3 * N * P) @(negedge clk);
    // Disable with the reference held high R9
    ref_in = 1'b1;
    @(negedge clk) en = 1'b0;
    repeat (20) begin
      @(negedge clk);
      chk(!clk_out && !marker && !match_stb && !align_stb, "R9 idle outputs",
          {clk_out, marker, match_stb, align_stb}, 0);
    end
    en = 1'b1;
    aligns = 0;
    repeat (40) begin
      @(negedge clk);
      if (align_stb) aligns++;
    end
    chk(aligns == 0, "R9 no edge after enable", aligns, 0);
    ref_in = 1'b0;
    repeat (10) @(negedge clk);
    for (int i = 0; i < 24; i++) pulse(2 + i % 3, 25 + (i * 5) % (N * P));
    repeat (3 * N * P) @(negedge clk);
    finish_run();
  end
endmodule